// File: doc/BRIEF.md
# SD Host Data-Path Byte and Timeout Counter

This block sequences one block-oriented data transfer of an SD host. Configuration arrives as three words: a data timeout in card clock cycles, a total byte length, and a control word with enable, direction, a log2 block size and a FIFO flush strobe. Writing the control word with its enable bit set arms the path. From then on the serialiser reports every byte it moves, every cycle spent waiting for a start bit or for busy to release, and any CRC, underrun or overrun event.

The block keeps a live count of the bytes still to move and pulses a block-end flag at every block boundary. It raises data-end when the count reaches zero and raises a timeout if the waiting stretch outlasts the programmed limit. Any error freezes the path. The remaining count stays readable afterwards, so software can see whether a CRC failure struck before the final byte. Flags are sticky until the next enabling write.

Top module: `sd_dpath_ctr`

## Requirements
- R1: After reset the status word, the remaining count and the direction output are all zero.
- R2: A control write with bit 0 set loads the remaining count from the length input and latches direction from bit 1 (1 = card to host) and the block-size exponent from bits 7:4. It also clears every status flag and sets the active flag (status bit 12) when the length is non-zero, all visible the cycle after the write.
- R3: While active and error-free, each cycle with the byte strobe lowers the remaining count by exactly one.
- R4: Block-end (status bit 10) is high for one cycle after each byte that completes a block of 2^exponent bytes, counted from the enabling write.
- R5: When the remaining count reaches zero, data-end (status bit 8) sets and active clears in the same cycle. An enabling write with length zero sets data-end at once and never sets active.
- R6: The timeout counter loads from the timeout input on enable and reloads on every byte. In each active waiting cycle without a byte it decrements, or sets the timeout flag (status bit 3) and stops the path if it already holds zero. A limit of N therefore expires on the (N+1)-th consecutive waiting cycle.
- R7: A CRC-fail event while active sets status bit 1 and stops the path with the remaining count frozen.
- R8: An underrun event sets status bit 4 only in the host-to-card direction. An overrun event sets status bit 5 only in the card-to-host direction. Events in the other direction are ignored.
- R9: After any error or after data-end, bytes, waiting cycles and events have no effect on the count or flags until the next enabling write.
- R10: A control write with bit 0 clear stops an active transfer and leaves the remaining count and the flags unchanged.
- R11: A control write with bit 13 set drives the FIFO flush output high in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_i | input | 14 | Control word (bit 0 enable, bit 1 direction, 7:4 block exponent, 13 FIFO flush) |
| len_i | input | 25 | Total transfer length in bytes |
| tmo_i | input | 32 | Data timeout in card clock cycles |
| byte_i | input | 1 | One byte moved by the serialiser |
| wait_i | input | 1 | Path waiting for start bit or busy release |
| crc_err_i | input | 1 | Data CRC failure event |
| undr_i | input | 1 | Transmit underrun event |
| ovr_i | input | 1 | Receive overrun event |
| sts_o | output | 13 | Status flags (1 CRC, 3 timeout, 4 underrun, 5 overrun, 8 data-end, 10 block-end, 12 active) |
| remain_o | output | 25 | Bytes still to transfer |
| dir_o | output | 1 | Latched direction |
| fifo_flush_o | output | 1 | FIFO flush pulse |

## Verification
The assertions assume that the configuration inputs hold steady across a control write and that the byte strobe means exactly one byte per high cycle. They also assume the block exponent stays within the 4-bit field. The stimulus drives every input on the falling edge and changes configuration only together with a control write. It raises at most one strobe per cycle, except where it deliberately combines a byte with waiting or sends events in the wrong direction to exercise the corner cases.

// File: rtl/sd_dpath_ctr.sv
module sd_dpath_ctr #(
  parameter int LEN_W = 25,
  parameter int TMO_W = 32,
  parameter int BSZ_W = 4,
  parameter int CTL_W = 14,
  parameter int STS_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [CTL_W-1:0] ctrl_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             byte_i,
  input  logic             wait_i,
  input  logic             crc_err_i,
  input  logic             undr_i,
  input  logic             ovr_i,
  output logic [STS_W-1:0] sts_o,
  output logic [LEN_W-1:0] remain_o,
  output logic             dir_o,
  output logic             fifo_flush_o
);
  localparam int BLK_W = 1 << BSZ_W;

  logic             act, dir, f_crc, f_tmo, f_und, f_ovr, f_dend, p_bend;
  logic [BSZ_W-1:0] bsz;
  logic [LEN_W-1:0] rem;
  logic [TMO_W-1:0] tmo_val, tmo_cnt;
  logic [BLK_W-1:0] blk_cnt;

  logic en_w, tmo_hit, und_hit, ovr_hit, err, blk_last;
  logic unused_ctrl;

  assign en_w     = ctrl_we & ctrl_i[0];
  assign tmo_hit  = wait_i & ~byte_i & (tmo_cnt == '0);
  assign und_hit  = undr_i & ~dir;
  assign ovr_hit  = ovr_i & dir;
  assign err      = crc_err_i | und_hit | ovr_hit | tmo_hit;
  assign blk_last = blk_cnt == ((BLK_W'(1) << bsz) - BLK_W'(1));
  assign unused_ctrl = ^{ctrl_i[12:8], ctrl_i[3:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= 1'b0;
      dir     <= 1'b0;
      bsz     <= '0;
      rem     <= '0;
      tmo_val <= '0;
      tmo_cnt <= '0;
      blk_cnt <= '0;
      f_crc   <= 1'b0;
      f_tmo   <= 1'b0;
      f_und   <= 1'b0;
      f_ovr   <= 1'b0;
      f_dend  <= 1'b0;
      p_bend  <= 1'b0;
    end else begin
      p_bend <= 1'b0;
      if (en_w) begin
        dir     <= ctrl_i[1];
        bsz     <= ctrl_i[7:4];
        rem     <= len_i;
        tmo_val <= tmo_i;
        tmo_cnt <= tmo_i;
        blk_cnt <= '0;
        f_crc   <= 1'b0;
        f_tmo   <= 1'b0;
        f_und   <= 1'b0;
        f_ovr   <= 1'b0;
        f_dend  <= (len_i == '0);
        act     <= (len_i != '0);
      end else if (ctrl_we) begin
        act <= 1'b0;
      end else if (act) begin
        if (err) begin
          act <= 1'b0;
          if (crc_err_i) f_crc <= 1'b1;
          if (und_hit)   f_und <= 1'b1;
          if (ovr_hit)   f_ovr <= 1'b1;
          if (tmo_hit)   f_tmo <= 1'b1;
        end else if (byte_i) begin
          rem     <= rem - LEN_W'(1);
          tmo_cnt <= tmo_val;
          if (blk_last) begin
            p_bend  <= 1'b1;
            blk_cnt <= '0;
          end else begin
            blk_cnt <= blk_cnt + BLK_W'(1);
          end
          if (rem == LEN_W'(1)) begin
            f_dend <= 1'b1;
            act    <= 1'b0;
          end
        end else if (wait_i) begin
          tmo_cnt <= tmo_cnt - TMO_W'(1);
        end
      end
    end
  end

  always_comb begin
    sts_o     = '0;
    sts_o[1]  = f_crc;
    sts_o[3]  = f_tmo;
    sts_o[4]  = f_und;
    sts_o[5]  = f_ovr;
    sts_o[8]  = f_dend;
    sts_o[10] = p_bend;
    sts_o[12] = act;
  end

  assign remain_o     = rem;
  assign dir_o        = dir;
  assign fifo_flush_o = ctrl_we & ctrl_i[13];
endmodule

// File: rtl/sd_dpath_ctr_chk.sv
module sd_dpath_ctr_chk #(
  parameter int LEN_W = 25,
  parameter int TMO_W = 32,
  parameter int BSZ_W = 4,
  parameter int CTL_W = 14,
  parameter int STS_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic [CTL_W-1:0] ctrl_i,
  input logic [LEN_W-1:0] len_i,
  input logic [TMO_W-1:0] tmo_i,
  input logic             byte_i,
  input logic             wait_i,
  input logic             crc_err_i,
  input logic             undr_i,
  input logic             ovr_i,
  input logic [STS_W-1:0] sts_o,
  input logic [LEN_W-1:0] remain_o,
  input logic             dir_o,
  input logic             fifo_flush_o
);
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && ctrl_i[0] |=> remain_o == $past(len_i)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sts_o[12] && !ctrl_we |=> (remain_o == $past(remain_o)) || (remain_o == $past(remain_o) - 1'b1)); // R3
  AST_BLOCK_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_o[10] |-> $past(byte_i && sts_o[12])); // R4
  AST_DATA_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_o[8] |-> !sts_o[12]); // R5
  AST_CRC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_o[1]) |-> !sts_o[12] && $stable(remain_o)); // R7
  AST_UNDERRUN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    sts_o[4] |-> !dir_o); // R8
  AST_OVERRUN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    sts_o[5] |-> dir_o); // R8
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_o[12] && !ctrl_we |=> $stable(remain_o) && !sts_o[12]); // R9
  AST_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !ctrl_i[0] |=> !sts_o[12] && remain_o == $past(remain_o)); // R10
  AST_FLUSH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush_o |-> ctrl_we); // R11
endmodule

bind sd_dpath_ctr sd_dpath_ctr_chk #(
  .LEN_W(LEN_W), .TMO_W(TMO_W), .BSZ_W(BSZ_W), .CTL_W(CTL_W), .STS_W(STS_W)
) u_chk (.*);

// File: tb/sd_dpath_ctr_tb.sv
module sd_dpath_ctr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [13:0] ctrl_i = '0;
  logic [24:0] len_i = '0;
  logic [31:0] tmo_i = '0;
  logic        byte_i = 1'b0, wait_i = 1'b0, crc_err_i = 1'b0, undr_i = 1'b0, ovr_i = 1'b0;
  logic [12:0] sts_o;
  logic [24:0] remain_o;
  logic        dir_o, fifo_flush_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sd_dpath_ctr u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_i(ctrl_i), .len_i(len_i),
    .tmo_i(tmo_i), .byte_i(byte_i), .wait_i(wait_i), .crc_err_i(crc_err_i),
    .undr_i(undr_i), .ovr_i(ovr_i), .sts_o(sts_o), .remain_o(remain_o),
    .dir_o(dir_o), .fifo_flush_o(fifo_flush_o));

  // behavioural reference state
  int     m_rem, m_bsz, m_bcnt;
  longint m_tval, m_tcnt;
  bit     m_act, m_dir, m_crc, m_tmo, m_und, m_ovr, m_dend, m_bend;

  always @(posedge clk) begin : model
    bit th, ue, oe;
    if (!rst_n) begin
      m_rem = 0; m_bsz = 0; m_bcnt = 0; m_tval = 0; m_tcnt = 0;
      m_act = 0; m_dir = 0; m_crc = 0; m_tmo = 0; m_und = 0; m_ovr = 0;
      m_dend = 0; m_bend = 0;
    end else begin
      m_bend = 0;
      if (ctrl_we && ctrl_i[0]) begin
        m_dir = ctrl_i[1]; m_bsz = int'(ctrl_i[7:4]); m_rem = int'(len_i);
        m_tval = longint'(tmo_i); m_tcnt = m_tval; m_bcnt = 0;
        m_crc = 0; m_tmo = 0; m_und = 0; m_ovr = 0;
        m_dend = (len_i == 0); m_act = (len_i != 0);
      end else if (ctrl_we) begin
        m_act = 0;
      end else if (m_act) begin
        th = wait_i && !byte_i && m_tcnt == 0;
        ue = undr_i && !m_dir;
        oe = ovr_i && m_dir;
        if (crc_err_i || ue || oe || th) begin
          m_act = 0;
          if (crc_err_i) m_crc = 1;
          if (ue) m_und = 1;
          if (oe) m_ovr = 1;
          if (th) m_tmo = 1;
        end else if (byte_i) begin
          m_rem--; m_tcnt = m_tval; m_bcnt++;
          if (m_bcnt == (1 << m_bsz)) begin m_bend = 1; m_bcnt = 0; end
          if (m_rem == 0) begin m_dend = 1; m_act = 0; end
        end else if (wait_i) begin
          m_tcnt--;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act_v, exp_v, $time);
    end
  endtask

  // compare against model every cycle, after the edge settles
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(int'(remain_o) == m_rem, "R3 remain", remain_o, m_rem);
      chk(sts_o[12] == m_act, "R2 active", sts_o[12], m_act);
      chk(dir_o == m_dir, "R2 dir", dir_o, m_dir);
      chk(sts_o[10] == m_bend, "R4 block-end", sts_o[10], m_bend);
      chk(sts_o[8] == m_dend, "R5 data-end", sts_o[8], m_dend);
      chk(sts_o[3] == m_tmo, "R6 timeout", sts_o[3], m_tmo);
      chk(sts_o[1] == m_crc, "R7 crc", sts_o[1], m_crc);
      chk(sts_o[4] == m_und && sts_o[5] == m_ovr, "R8 under/over",
          {sts_o[5], sts_o[4]}, {m_ovr, m_und});
      chk(fifo_flush_o == (ctrl_we && ctrl_i[13]), "R11 flush", fifo_flush_o, ctrl_we && ctrl_i[13]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ctrl_we = 0; byte_i = 0; wait_i = 0; crc_err_i = 0; undr_i = 0; ovr_i = 0;
    end
  endtask

  task automatic wr(input bit en, input bit d, input int bs, input int len, input longint tmo, input bit fl);
    @(negedge clk);
    byte_i = 0; wait_i = 0; crc_err_i = 0; undr_i = 0; ovr_i = 0;
    ctrl_we = 1; ctrl_i = '0;
    ctrl_i[0] = en; ctrl_i[1] = d; ctrl_i[7:4] = 4'(bs); ctrl_i[13] = fl;
    len_i = 25'(len); tmo_i = 32'(tmo);
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic bytes(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_i = 1;
      for (int g = 0; g < gap; g++) begin @(negedge clk); byte_i = 0; wait_i = 1; end
      @(negedge clk); byte_i = 0; wait_i = 0;
      idle(0);
    end
  endtask

  task automatic ev(input bit c, input bit u, input bit o);
    @(negedge clk); crc_err_i = c; undr_i = u; ovr_i = o;
    @(negedge clk); crc_err_i = 0; undr_i = 0; ovr_i = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk(sts_o == 0 && remain_o == 0 && dir_o == 0, "R1 reset state", {sts_o, remain_o}, 0);
    // transmit, 8 bytes, blocks of 4
    wr(1, 0, 2, 8, 100, 0);
    bytes(8, 1);
    idle(3);
    // receive, blocks of 2, CRC after 3 bytes
    wr(1, 1, 1, 5, 100, 0);
    bytes(3, 0);
    ev(1, 0, 0);
    bytes(2, 0);
    @(negedge clk);
    chk(remain_o == 2 && sts_o[12] == 0, "R9 frozen after crc", remain_o, 2);
    // zero length
    wr(1, 0, 0, 0, 10, 0);
    idle(2);
    // timeout: limit 3, interrupted by a byte
    wr(1, 0, 3, 20, 3, 0);
    @(negedge clk); wait_i = 1;
    @(negedge clk);
    @(negedge clk); byte_i = 1;
    @(negedge clk); byte_i = 0;
    repeat (6) @(negedge clk);
    wait_i = 0;
    idle(2);
    // receive: underrun ignored, overrun recorded
    wr(1, 1, 0, 10, 50, 0);
    ev(0, 1, 0);
    bytes(1, 0);
    ev(0, 0, 1);
    idle(2);
    // transmit: overrun ignored, underrun recorded
    wr(1, 0, 0, 10, 50, 0);
    ev(0, 0, 1);
    ev(0, 1, 0);
    idle(2);
    // stop by writing enable clear, with flush
    wr(1, 1, 2, 30, 50, 0);
    bytes(5, 0);
    wr(0, 0, 0, 99, 0, 1);
    @(negedge clk);
    chk(remain_o == 25 && sts_o[12] == 0 && dir_o == 1, "R10 stop keeps count", remain_o, 25);
    bytes(2, 0);
    // back-to-back single-byte blocks
    wr(1, 1, 0, 6, 5, 1);
    @(negedge clk); byte_i = 1;
    repeat (5) @(negedge clk);
    byte_i = 0; wait_i = 1;
    @(negedge clk); byte_i = 1;
    @(negedge clk); byte_i = 0; wait_i = 0;
    idle(3);
    // long timeout value
    wr(1, 1, 4, 1000, 64'hFFFF_FFFF, 0);
    @(negedge clk); wait_i = 1;
    repeat (20) @(negedge clk);
    wait_i = 0;
    idle(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule